// File: doc/BRIEF.md
# Core Module Control Register File

This block is the word-addressed control and status register set of a processor core module. A bus master reads a fixed identification word and a status word through it. The master also programs two oscillator words, an SDRAM configuration word, an init word, and two flag words. The flag words have separate set and clear addresses. The oscillator words can be changed only while a 16-bit unlock key sits in the lock register.

A control word drives an LED output and a boot-remap output, and can request a system reset. The block also exposes a read-only memory-module SPD byte window. It holds a small local interrupt mask set, in which one software-driven level bit is gated separately into an IRQ request and an FIQ request.

Byte offsets on the bus are turned into word indices by dropping the two low address bits. Reads return data in the same cycle as the request. A write takes effect at the clock edge on which it is presented.

Top module: `coremod_regfile`

## Requirements
- R1: After reset, the oscillator word reads 0x01000048, the auxiliary oscillator word reads 0x0007FEFF, the init word reads 0x00000112, and the SDRAM word reads 0x00011122 ORed with the size code. The size code comes from parameter MEM_MB: 0x10 for at least 256, 0x0C for at least 128 (the default, giving 0x0001112E), 0x08 for at least 64, 0x04 for at least 32, and 0 otherwise. After reset the lock, control, flag and interrupt state are all zero.
- R2: Word index 0 always reads 0x411A3001. Word index 4 always reads 0x00100000.
- R3: A write to index 5 keeps only the low 16 bits of the data. If the kept value is 0xA05F, a read of index 5 returns 0x0001A05F. Otherwise it returns the kept value with bits 31:16 at zero.
- R4: Writes to index 2 (oscillator) and index 7 (auxiliary oscillator) replace the whole word only while the lock value is 0xA05F. At any other time they are dropped.
- R5: A write to index 3 updates only bit 0 (drives `led`) and bit 2 (drives `remap`; while it is 0, boot flash sits at address 0). A read of index 3 shows these two bits and returns zero in every other bit, bit 3 included.
- R6: A write to index 3 with data bit 3 set raises `reset_req` for exactly the one clock cycle after the write edge.
- R7: A write to index 12 ORs the data into the flags word. A write to index 13 clears the bits that are set in the data. A read of index 12 returns the flags word.
- R8: Indices 14 and 15 set and clear the non-volatile flags word in the same way, and a read of index 14 returns it.
- R9: Byte offsets 0x100 to 0x17F read SPD byte (offset-0x100)>>2, zero-extended. Byte 0 is 128, byte 9 is 0xA0, and byte 31 is 32 when MEM_MB is 128. Offsets 0x180 to 0x1FF read zero.
- R10: Indices 18/19 set and clear IRQ enable bits, and indices 26/27 do the same for FIQ enable bits. Reads of 18 and 26 return the enables. Reads of 17 and 25 return the raw level. Reads of 16 and 24 return the level ANDed with the matching enable. `irq` and `fiq` are high while that AND is non-zero.
- R11: Writes to index 20 set, and writes to index 21 clear, only level bit 0, under control of data bit 0. A read of index 20 returns level bit 0.
- R12: Indices 6 and 10 (counters), 32 to 35 (voltage control) and every other unlisted index read zero. Writes to them change no state.
- R13: Writes to index 8 (SDRAM) and index 9 (init) replace the whole word with no lock check.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the request cycle, zero otherwise |
| led | output | 1 | Control bit 0 |
| remap | output | 1 | Control bit 2 |
| reset_req | output | 1 | One-cycle reset request pulse |
| irq | output | 1 | Enabled IRQ level present |
| fiq | output | 1 | Enabled FIQ level present |

## Verification
On every cycle, the bound checker confirms several properties. The reset request is a lone pulse that only a control write with bit 3 can cause. `led` and `remap` move only on a control write. Control reads never show bits 1 or 3. Lock reads keep the upper bits clear, the identity and voltage indices read their fixed values, and clearing all IRQ enables drops `irq`. The value-dependent behaviour can only be shown by the directed scenarios, which read registers back after chosen writes. That behaviour includes the reset contents, the key gating of the oscillator words, set/clear accumulation in the flag words, the SPD table contents and window edge, and bit-0-only soft interrupts.

// File: rtl/coremod_regfile.sv
module coremod_regfile #(
  parameter int ADDR_W = 10,
  parameter int MEM_MB = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              led,
  output logic              remap,
  output logic              reset_req,
  output logic              irq,
  output logic              fiq
);
  localparam int IW = ADDR_W - 2;
  localparam logic [31:0] SIZE_CODE = (MEM_MB >= 256) ? 32'h10 :
                                      (MEM_MB >= 128) ? 32'h0C :
                                      (MEM_MB >= 64)  ? 32'h08 :
                                      (MEM_MB >= 32)  ? 32'h04 : 32'h0;
  localparam logic [7:0] SPD_SIZE = (MEM_MB >= 256) ? 8'd64 :
                                    (MEM_MB >= 128) ? 8'd32 :
                                    (MEM_MB >= 64)  ? 8'd16 :
                                    (MEM_MB >= 32)  ? 8'd4  : 8'd2;
  localparam logic [15:0] KEY = 16'hA05F;

  logic [IW-1:0] idx;
  logic          wr_en, rd_en, unlocked;
  logic [31:0]   osc_q, aux_q, sdram_q, init_q, flags_q, nvflags_q;
  logic [31:0]   irq_en_q, fiq_en_q;
  logic [15:0]   lock_q;
  logic          soft_q;
  logic [31:0]   level, rd_val;
  logic          unused_addr_lsb;

  assign idx             = bus_addr[ADDR_W-1:2];
  assign unused_addr_lsb = ^bus_addr[1:0];
  assign wr_en           = bus_sel & bus_wr;
  assign rd_en           = bus_sel & ~bus_wr;
  assign unlocked        = (lock_q == KEY);
  assign level           = {31'b0, soft_q};
  assign irq             = |(level & irq_en_q);
  assign fiq             = |(level & fiq_en_q);

  function automatic logic [7:0] spd_byte(input logic [4:0] n);
    case (n)
      5'd0:  spd_byte = 8'd128;
      5'd1:  spd_byte = 8'd8;
      5'd2:  spd_byte = 8'd4;
      5'd3:  spd_byte = 8'd11;
      5'd4:  spd_byte = 8'd9;
      5'd5:  spd_byte = 8'd1;
      5'd6:  spd_byte = 8'd64;
      5'd8:  spd_byte = 8'd2;
      5'd9:  spd_byte = 8'hA0;
      5'd10: spd_byte = 8'hA0;
      5'd13: spd_byte = 8'd8;
      5'd15: spd_byte = 8'd1;
      5'd16: spd_byte = 8'h0E;
      5'd17: spd_byte = 8'd4;
      5'd18: spd_byte = 8'h1C;
      5'd19: spd_byte = 8'd1;
      5'd20: spd_byte = 8'd2;
      5'd21: spd_byte = 8'h20;
      5'd22: spd_byte = 8'hC0;
      5'd27: spd_byte = 8'h30;
      5'd28: spd_byte = 8'h28;
      5'd29: spd_byte = 8'h30;
      5'd30: spd_byte = 8'h28;
      5'd31: spd_byte = SPD_SIZE;
      default: spd_byte = 8'h00;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      osc_q     <= 32'h0100_0048;
      aux_q     <= 32'h0007_FEFF;
      sdram_q   <= 32'h0001_1122 | SIZE_CODE;
      init_q    <= 32'h0000_0112;
      lock_q    <= '0;
      led       <= 1'b0;
      remap     <= 1'b0;
      reset_req <= 1'b0;
      flags_q   <= '0;
      nvflags_q <= '0;
      irq_en_q  <= '0;
      fiq_en_q  <= '0;
      soft_q    <= 1'b0;
    end else begin
      reset_req <= 1'b0;
      if (wr_en) begin
        case (idx)
          IW'(2):  if (unlocked) osc_q <= bus_wdata;
          IW'(3):  begin
                     led       <= bus_wdata[0];
                     remap     <= bus_wdata[2];
                     reset_req <= bus_wdata[3];
                   end
          IW'(5):  lock_q    <= bus_wdata[15:0];
          IW'(7):  if (unlocked) aux_q <= bus_wdata;
          IW'(8):  sdram_q   <= bus_wdata;
          IW'(9):  init_q    <= bus_wdata;
          IW'(12): flags_q   <= flags_q | bus_wdata;
          IW'(13): flags_q   <= flags_q & ~bus_wdata;
          IW'(14): nvflags_q <= nvflags_q | bus_wdata;
          IW'(15): nvflags_q <= nvflags_q & ~bus_wdata;
          IW'(18): irq_en_q  <= irq_en_q | bus_wdata;
          IW'(19): irq_en_q  <= irq_en_q & ~bus_wdata;
          IW'(20): if (bus_wdata[0]) soft_q <= 1'b1;
          IW'(21): if (bus_wdata[0]) soft_q <= 1'b0;
          IW'(26): fiq_en_q  <= fiq_en_q | bus_wdata;
          IW'(27): fiq_en_q  <= fiq_en_q & ~bus_wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rd_val = '0;
    if (idx >= IW'(64) && idx < IW'(96)) begin
      rd_val = {24'b0, spd_byte(idx[4:0])};
    end else begin
      case (idx)
        IW'(0):  rd_val = 32'h411A_3001;
        IW'(2):  rd_val = osc_q;
        IW'(3):  rd_val = {29'b0, remap, 1'b0, led};
        IW'(4):  rd_val = 32'h0010_0000;
        IW'(5):  rd_val = {15'b0, unlocked, lock_q};
        IW'(7):  rd_val = aux_q;
        IW'(8):  rd_val = sdram_q;
        IW'(9):  rd_val = init_q;
        IW'(12): rd_val = flags_q;
        IW'(14): rd_val = nvflags_q;
        IW'(16): rd_val = level & irq_en_q;
        IW'(17): rd_val = level;
        IW'(18): rd_val = irq_en_q;
        IW'(20): rd_val = {31'b0, soft_q};
        IW'(24): rd_val = level & fiq_en_q;
        IW'(25): rd_val = level;
        IW'(26): rd_val = fiq_en_q;
        default: rd_val = '0;
      endcase
    end
  end

  assign bus_rdata = rd_en ? rd_val : 32'h0;
endmodule

// File: rtl/coremod_regfile_chk.sv
module coremod_regfile_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic              led,
  input logic              remap,
  input logic              reset_req,
  input logic              irq,
  input logic              fiq
);
  localparam int IW = ADDR_W - 2;
  logic [IW-1:0] c_idx;
  logic c_wr, c_rd, c_ctrl_wr, unused_chk;
  assign c_idx      = bus_addr[ADDR_W-1:2];
  assign c_wr       = bus_sel & bus_wr;
  assign c_rd       = bus_sel & ~bus_wr;
  assign c_ctrl_wr  = c_wr && (c_idx == IW'(3));
  assign unused_chk = ^{bus_addr[1:0], fiq};

  AST_RESET_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> !reset_req); // R6
  AST_RESET_REQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> $past(c_ctrl_wr && bus_wdata[3])); // R6
  AST_LED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !c_ctrl_wr |=> $stable(led)); // R5
  AST_REMAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !c_ctrl_wr |=> $stable(remap)); // R5
  AST_CTRL_RD_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (c_rd && c_idx == IW'(3)) |-> (bus_rdata[31:3] == '0 && !bus_rdata[1])); // R5
  AST_LOCK_RD_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (c_rd && c_idx == IW'(5)) |-> (bus_rdata[31:17] == '0)); // R3
  AST_ID_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (c_rd && c_idx == IW'(0)) |-> (bus_rdata == 32'h411A_3001)); // R2
  AST_VOLT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (c_rd && c_idx >= IW'(32) && c_idx <= IW'(35)) |-> (bus_rdata == '0)); // R12
  AST_IRQ_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (c_wr && c_idx == IW'(19) && bus_wdata == 32'hFFFF_FFFF) |=> !irq); // R10
endmodule

bind coremod_regfile coremod_regfile_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .led(led), .remap(remap), .reset_req(reset_req), .irq(irq), .fiq(fiq)
);

// File: tb/coremod_regfile_tb_top.sv
`timescale 1ns/1ps
module coremod_regfile_tb_top;
  localparam int AW = 10;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic led, remap, reset_req, irq, fiq;
  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  coremod_regfile #(.ADDR_W(AW), .MEM_MB(128)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .led(led), .remap(remap), .reset_req(reset_req), .irq(irq), .fiq(fiq));

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = AW'(idx * 4); bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd_byte(input int off, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = AW'(off);
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic rdchk(input string req, input int idx, input logic [31:0] exp);
    logic [31:0] d;
    rd_byte(idx * 4, d);
    check(req, d, exp);
  endtask

  task automatic t_reset;
    rdchk("R1 osc", 2, 32'h0100_0048);
    rdchk("R1 aux", 7, 32'h0007_FEFF);
    rdchk("R1 init", 9, 32'h0000_0112);
    rdchk("R1 sdram", 8, 32'h0001_112E);
    rdchk("R1 lock", 5, 32'h0);
    rdchk("R1 ctrl", 3, 32'h0);
    check("R1 led/remap/irq", {29'b0, led, remap, irq}, 32'h0);
  endtask

  task automatic t_ident;
    rdchk("R2 id", 0, 32'h411A_3001);
    rdchk("R2 stat", 4, 32'h0010_0000);
  endtask

  task automatic t_lock_osc;
    wr(2, 32'h1234_5678);
    rdchk("R4 osc locked", 2, 32'h0100_0048);
    wr(5, 32'hDEAD_A05F);
    rdchk("R3 unlocked read", 5, 32'h0001_A05F);
    wr(2, 32'h1234_5678);
    rdchk("R4 osc unlocked", 2, 32'h1234_5678);
    wr(7, 32'h0000_0ABC);
    rdchk("R4 aux unlocked", 7, 32'h0000_0ABC);
    wr(5, 32'hFFFF_1111);
    rdchk("R3 other key", 5, 32'h0000_1111);
    wr(7, 32'h5555_5555);
    rdchk("R4 aux relocked", 7, 32'h0000_0ABC);
  endtask

  task automatic t_ctrl;
    wr(3, 32'hFFFF_FFF7);
    rdchk("R5 ctrl bits", 3, 32'h0000_0005);
    check("R5 led", {31'b0, led}, 1);
    check("R5 remap", {31'b0, remap}, 1);
    check("R6 no pulse", {31'b0, reset_req}, 0);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = AW'(12); bus_wdata = 32'h0000_0008;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    check("R6 pulse high", {31'b0, reset_req}, 1);
    @(negedge clk);
    check("R6 pulse low", {31'b0, reset_req}, 0);
    rdchk("R5 bit3 reads 0", 3, 32'h0);
    check("R5 remap cleared", {31'b0, remap}, 0);
  endtask

  task automatic t_flags;
    wr(12, 32'h0000_F0F0);
    wr(12, 32'h0000_000F);
    rdchk("R7 set", 12, 32'h0000_F0FF);
    wr(13, 32'h0000_F001);
    rdchk("R7 clear", 12, 32'h0000_00FE);
    wr(14, 32'h8000_0001);
    wr(15, 32'h0000_0001);
    rdchk("R8 nv", 14, 32'h8000_0000);
    rdchk("R7 untouched by nv", 12, 32'h0000_00FE);
  endtask

  task automatic t_spd;
    logic [31:0] d;
    rd_byte(32'h100, d); check("R9 spd0", d, 32'd128);
    rd_byte(32'h124, d); check("R9 spd9", d, 32'hA0);
    rd_byte(32'h17C, d); check("R9 spd31", d, 32'd32);
    rd_byte(32'h180, d); check("R9 past window", d, 32'h0);
    rd_byte(32'h1FC, d); check("R9 window end", d, 32'h0);
  endtask

  task automatic t_irq;
    wr(20, 32'hFFFF_FFFE);
    rdchk("R11 bit0 only set", 17, 32'h0);
    wr(20, 32'h0000_0001);
    rdchk("R11 soft read", 20, 32'h1);
    rdchk("R10 raw", 25, 32'h1);
    check("R10 irq off", {31'b0, irq}, 0);
    wr(18, 32'h0000_0003);
    rdchk("R10 irq en", 18, 32'h3);
    rdchk("R10 irq stat", 16, 32'h1);
    check("R10 irq on", {31'b0, irq}, 1);
    wr(26, 32'h0000_0001);
    check("R10 fiq on", {31'b0, fiq}, 1);
    rdchk("R10 fiq stat", 24, 32'h1);
    wr(19, 32'h0000_0001);
    rdchk("R10 irq en clr", 18, 32'h2);
    check("R10 irq dropped", {31'b0, irq}, 0);
    wr(21, 32'h0000_0002);
    rdchk("R11 clr bit1 no effect", 17, 32'h1);
    wr(21, 32'h0000_0001);
    check("R11 fiq dropped", {31'b0, fiq}, 0);
    wr(27, 32'h0000_0001);
    rdchk("R10 fiq en clr", 26, 32'h0);
  endtask

  task automatic t_sdram_init;
    wr(8, 32'hCAFE_0001);
    rdchk("R13 sdram", 8, 32'hCAFE_0001);
    wr(9, 32'h0BAD_F00D);
    rdchk("R13 init", 9, 32'h0BAD_F00D);
  endtask

  task automatic t_unimpl;
    rdchk("R12 counter6", 6, 32'h0);
    rdchk("R12 counter10", 10, 32'h0);
    wr(33, 32'hFFFF_FFFF);
    rdchk("R12 volt", 33, 32'h0);
    wr(1, 32'hFFFF_FFFF);
    wr(40, 32'hFFFF_FFFF);
    rdchk("R12 idx1", 1, 32'h0);
    rdchk("R12 idx40", 40, 32'h0);
    rdchk("R12 no osc change", 2, 32'h1234_5678);
    rdchk("R12 no flag change", 12, 32'h0000_00FE);
    check("R12 outputs", {28'b0, led, remap, irq, fiq}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ident();
    t_lock_osc();
    t_ctrl();
    t_flags();
    t_spd();
    t_irq();
    t_sdram_init();
    t_unimpl();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule